// File: doc/BRIEF.md
# Vectored Interrupt Controller with Call-Instruction Acknowledge

This block collects eight interrupt request lines and presents one active-high interrupt output to a processor on a byte-wide bus. The request lines are asynchronous to the bus clock. Each line can be set to edge or level sensing. A mask register can silence single lines. A fixed priority order, with line 0 highest, decides which request may interrupt, and an in-service register records the requests the processor is still handling.

The processor answers the interrupt with three active-low acknowledge strobes. On these strobes the block returns a three-byte subroutine-call instruction: first the opcode, then the low byte and then the high byte of the service-routine address. That address is a programmable 16-bit base plus the line index times a spacing of 4 or 8 bytes. The first strobe picks the winning request, moves it into service and clears its edge latch. The processor writes a non-specific end-of-interrupt command to retire the highest-priority request in service.

Bus accesses are synchronous to `clk`. A write takes effect on the first clock edge that sees chip select and write low together. Reads and the acknowledge bytes appear combinationally on `rdata`.

Top module: `vic_callseq`

## Requirements
- R1: After reset `int_out` is low and `rdata` is 8'h00 when idle. The mask and trigger registers are zero (all lines edge-sensed and unmasked), the base is 16'h0000 and the spacing is 4.
- R2: A line in edge mode (trigger bit 0) passes through a two-flop synchronizer. A rising edge latches a request, and the request stays pending after the input falls.
- R3: A line in level mode (trigger bit 1) is pending exactly while its synchronized input is high, and no latch holds it.
- R4: `int_out` is high exactly when some pending, unmasked line has a lower index than every line in service. Line 0 has the highest priority.
- R5: While `ack_n` is low, `rdata` carries the byte for the current strobe: 8'hCD on the first strobe, the address low byte on the second and the address high byte on the third. The strobe count advances when `ack_n` rises.
- R6: The call address is base + index × spacing. The spacing is 4 when configuration bit 3 is 0 and 8 when it is 1.
- R7: On the first strobe the winning line is set in the in-service register and its edge latch is cleared.
- R8: A line whose mask bit is 1 neither raises `int_out` nor wins an acknowledge.
- R9: A write to address 0 with bit 7 set (end of interrupt) clears the lowest-index set bit of the in-service register.
- R10: A write to address 0 with bit 7 clear sets the register selector to bits 2:0 and the spacing to bit 3. Address 1 writes or reads the selected register: 0 mask, 1 trigger, 2 base low, 3 base high, 4 in-service (read only). A read from address 0 returns the pending vector.
- R11: If nothing may win on the first strobe, the address bytes are those of line 7 and the in-service register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Command/status address bit |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data, or acknowledge byte while `ack_n` is low |
| irq_in | input | 8 | Asynchronous request lines, index 0 highest priority |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low |
| int_out | output | 1 | Interrupt to the processor, active high |

## Verification
Assertions check on every cycle that a synchronized rising edge always leaves a pending latch and that the strobe counter moves on each release. They also check that the held vector changes only on the first strobe, that the first strobe adds exactly one in-service bit when a line wins, and that end-of-interrupt removes exactly one. While the interrupt is raised they check that no masked or out-ranked line is the candidate. Only the bench scenarios can show the byte values of the call instruction for each spacing and base, nesting under a higher-priority request, a level request re-raising after end-of-interrupt, and the spurious acknowledge returning the line-7 address.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_IRQ     = 8;
  localparam int IDX_W       = $clog2(NUM_IRQ);
  localparam int SYNC_STAGES = 2;
  localparam int VEC_W       = 16;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [2:0] {
    SEL_MASK    = 3'd0,
    SEL_TRIG    = 3'd1,
    SEL_BASE_LO = 3'd2,
    SEL_BASE_HI = 3'd3,
    SEL_INSVC   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_LOW    = 2'd1,
    PH_HIGH   = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/vic_req_in.sv
module vic_req_in #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [STAGES-1:0][N-1:0] sync_q, sync_d;
  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] latch_q, latch_d;
  logic [N-1:0] edge_set;
  logic [N-1:0] synced;

  assign synced   = sync_q[STAGES-1];
  assign edge_set = synced & ~prev_q;

  always_comb begin
    sync_d[0] = irq_in;
    for (int k = 1; k < STAGES; k++) sync_d[k] = sync_q[k-1];
    prev_d  = synced;
    latch_d = (latch_q & ~clr) | edge_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign req[i] = trig_level[i] ? synced[i] : latch_q[i];

    assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_set[i] |=> latch_q[i]);
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     isr,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any
);
  logic [N-1:0] blocked;
  logic [N-1:0] cand;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      seen       = seen | isr[i];
      blocked[i] = seen;
    end
  end

  assign cand = req & ~mask & ~blocked;
  assign any  = |cand;

  always_comb begin
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) grant_idx = IDX_W'(i);
    end
    grant = any ? (N'(1) << grant_idx) : '0;
  end
endmodule

// File: rtl/vic_ack_seq.sv
module vic_ack_seq
  import vic_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int VW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [VW-1:0]    base,
  input  logic             spacing8,
  output logic             take,
  output logic [7:0]       ack_byte
);
  localparam logic [IDX_W-1:0] IDLE_IDX = '1;

  ack_phase_e       phase_q, phase_d;
  logic             ack_prev_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fall, rise;
  logic [VW-1:0]    target;

  assign fall = ~ack_n & ack_prev_q;
  assign rise = ack_n & ~ack_prev_q;
  assign take = fall & (phase_q == PH_OPCODE);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (rise) begin
      case (phase_q)
        PH_OPCODE: phase_d = PH_LOW;
        PH_LOW:    phase_d = PH_HIGH;
        default:   phase_d = PH_OPCODE;
      endcase
    end
    if (take) idx_d = any ? win_idx : IDLE_IDX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_OPCODE;
      ack_prev_q <= 1'b1;
      idx_q      <= IDLE_IDX;
    end else begin
      phase_q    <= phase_d;
      ack_prev_q <= ack_n;
      idx_q      <= idx_d;
    end
  end

  assign target = base + (spacing8 ? (VW'(idx_q) << 3) : (VW'(idx_q) << 2));

  always_comb begin
    case (phase_q)
      PH_OPCODE: ack_byte = CALL_OPCODE;
      PH_LOW:    ack_byte = target[7:0];
      default:   ack_byte = target[15:8];
    endcase
  end

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> phase_q != $past(phase_q));

  assert_idx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(idx_q));
endmodule

// File: rtl/vic_callseq.sv
module vic_callseq
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack_n,
  output logic               int_out
);
  localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_IRQ-1:0] mask_q, mask_d;
  logic [NUM_IRQ-1:0] trig_q, trig_d;
  logic [VEC_W-1:0]   base_q, base_d;
  logic               spc8_q, spc8_d;
  reg_sel_e           sel_q, sel_d;
  logic [NUM_IRQ-1:0] isr_q, isr_d;
  logic               wr_prev_q;

  logic               wr_act, wr_go, eoi, cfg_wr, data_wr;
  logic [NUM_IRQ-1:0] req, grant, clr, eoi_bit;
  logic [IDX_W-1:0]   grant_idx;
  logic               any, take;
  logic [7:0]         ack_byte, reg_rd;

  assign wr_act  = ~cs_n & ~wr_n;
  assign wr_go   = wr_act & ~wr_prev_q;
  assign eoi     = wr_go & ~addr & wdata[7];
  assign cfg_wr  = wr_go & ~addr & ~wdata[7];
  assign data_wr = wr_go & addr;
  assign eoi_bit = isr_q & (~isr_q + ONE);
  assign clr     = (take && any) ? grant : '0;

  vic_req_in #(.N(NUM_IRQ), .STAGES(SYNC_STAGES)) u_req (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .irq_in     (irq_in),
    .trig_level (trig_q),
    .clr        (clr),
    .req        (req)
  );

  vic_prio #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
    .req       (req),
    .mask      (mask_q),
    .isr       (isr_q),
    .grant     (grant),
    .grant_idx (grant_idx),
    .any       (any)
  );

  vic_ack_seq #(.IDX_W(IDX_W), .VW(VEC_W)) u_ack (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ack_n    (ack_n),
    .any      (any),
    .win_idx  (grant_idx),
    .base     (base_q),
    .spacing8 (spc8_q),
    .take     (take),
    .ack_byte (ack_byte)
  );

  always_comb begin
    mask_d = mask_q;
    trig_d = trig_q;
    base_d = base_q;
    spc8_d = spc8_q;
    sel_d  = sel_q;
    isr_d  = isr_q;
    if (cfg_wr) begin
      sel_d  = reg_sel_e'(wdata[2:0]);
      spc8_d = wdata[3];
    end
    if (data_wr) begin
      case (sel_q)
        SEL_MASK:    mask_d        = wdata;
        SEL_TRIG:    trig_d        = wdata;
        SEL_BASE_LO: base_d[7:0]   = wdata;
        SEL_BASE_HI: base_d[15:8]  = wdata;
        default:     ;
      endcase
    end
    if (eoi) isr_d = isr_d & ~eoi_bit;
    if (take && any) isr_d = isr_d | grant;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mask_q    <= '0;
      trig_q    <= '0;
      base_q    <= '0;
      spc8_q    <= 1'b0;
      sel_q     <= SEL_MASK;
      isr_q     <= '0;
      wr_prev_q <= 1'b0;
    end else begin
      mask_q    <= mask_d;
      trig_q    <= trig_d;
      base_q    <= base_d;
      spc8_q    <= spc8_d;
      sel_q     <= sel_d;
      isr_q     <= isr_d;
      wr_prev_q <= wr_act;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_MASK:    reg_rd = mask_q;
      SEL_TRIG:    reg_rd = trig_q;
      SEL_BASE_LO: reg_rd = base_q[7:0];
      SEL_BASE_HI: reg_rd = base_q[15:8];
      SEL_INSVC:   reg_rd = isr_q;
      default:     reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    if (!ack_n)              rdata = ack_byte;
    else if (!cs_n && !rd_n) rdata = addr ? reg_rd : req;
    else                     rdata = 8'h00;
  end

  assign int_out = any;

  assert_int_outranks_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    int_out |-> (((grant | (grant - ONE)) & isr_q) == '0));

  assert_grant_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    int_out |-> ($onehot(grant) && ((grant & mask_q) == '0)));

  assert_take_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (take && any && !eoi) |=> $countones(isr_q & ~$past(isr_q)) == 1);

  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (eoi && (isr_q != '0) && !take) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: tb/vic_callseq_test.sv
module vic_callseq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       ack_n = 1'b1;
  logic       int_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int base_v   = 0;
  bit spc8     = 1'b0;

  always #10 clk = ~clk;

  vic_callseq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .ack_n(ack_n), .int_out(int_out)
  );

  // ---------------- behavioural reference model ----------------
  bit       m_r0, m_r1;
  bit [7:0] m_s0, m_s1, m_pv, m_lat, m_isr, m_mask, m_trig;
  bit       m_wp, m_ap;
  int       m_ph;
  int       m_sel;

  function automatic int m_pick();
    int top;
    top = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) top = i;
    for (int i = 0; i < 8; i++) begin
      if (i < top && !m_mask[i] && (m_trig[i] ? m_s1[i] : m_lat[i])) return i;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r0 <= 0; m_r1 <= 0; m_s0 <= 0; m_s1 <= 0; m_pv <= 0; m_lat <= 0;
      m_isr <= 0; m_mask <= 0; m_trig <= 0; m_wp <= 0; m_ap <= 1; m_ph <= 0; m_sel <= 0;
    end else begin
      m_r0 <= 1'b1;
      m_r1 <= m_r0;
      if (m_r1) begin
        bit [7:0] lat_n, isr_n;
        bit       w;
        int       k;
        lat_n = m_lat;
        isr_n = m_isr;
        w = !cs_n && !wr_n;
        if (w && !m_wp) begin
          if (!addr && wdata[7]) begin
            for (int i = 7; i >= 0; i--) k = 0;
            begin : eoi_blk
              for (int i = 0; i < 8; i++) if (m_isr[i]) begin isr_n[i] = 1'b0; disable eoi_blk; end
            end
          end else if (!addr) begin
            m_sel <= int'(wdata[2:0]);
          end else begin
            case (m_sel)
              0: m_mask <= wdata;
              1: m_trig <= wdata;
              default: ;
            endcase
          end
        end
        m_wp <= w;
        if (!ack_n && m_ap && m_ph == 0) begin
          k = m_pick();
          if (k >= 0) begin
            isr_n[k] = 1'b1;
            lat_n[k] = 1'b0;
          end
        end
        if (ack_n && !m_ap) m_ph <= (m_ph == 2) ? 0 : m_ph + 1;
        m_ap  <= ack_n;
        m_lat <= lat_n | (m_s1 & ~m_pv);
        m_isr <= isr_n;
        m_s0  <= irq_in;
        m_s1  <= m_s0;
        m_pv  <= m_s1;
      end
    end
  end

  // R4: interrupt output compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && m_r1) begin
      n_checks++;
      if (int_out !== (m_pick() >= 0)) begin
        n_fails++;
        $display("FAIL R4 cycle %0d: int_out=%0b expected %0b", cyc, int_out, (m_pick() >= 0));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input bit a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic select(input int sel);
    bus_wr(1'b0, {4'b0000, spc8, 3'(sel)});
  endtask

  task automatic ack_byte(output logic [7:0] b);
    @(negedge clk);
    ack_n = 0;
    @(negedge clk);
    b = rdata;
    ack_n = 1;
    @(negedge clk);
  endtask

  task automatic full_ack(input string tag, input int idx);
    logic [7:0] b;
    int target;
    target = base_v + idx * (spc8 ? 8 : 4);
    ack_byte(b); check({tag, " R5 opcode"}, b, 8'hCD);
    ack_byte(b); check({tag, " R6 low byte"}, b, target & 8'hFF);
    ack_byte(b); check({tag, " R6 high byte"}, b, (target >> 8) & 8'hFF);
  endtask

  task automatic read_isr(input string tag, input int exp);
    logic [7:0] d;
    select(4);
    bus_rd(1'b1, d);
    check(tag, d, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1;
    tick(4);

    // R1: reset state
    check("R1 int_out low", int_out, 0);
    check("R1 idle rdata", rdata, 0);
    bus_rd(1'b1, d); check("R1 mask zero", d, 0);
    select(1); bus_rd(1'b1, d); check("R1 trig zero", d, 0);

    // R10: program base 0x1240
    base_v = 16'h1240;
    select(2); bus_wr(1'b1, 8'h40);
    select(3); bus_wr(1'b1, 8'h12);
    select(2); bus_rd(1'b1, d); check("R10 base low readback", d, 8'h40);
    select(3); bus_rd(1'b1, d); check("R10 base high readback", d, 8'h12);

    // R2: edge pulse on line 3 stays pending
    irq_in[3] = 1; tick(3); irq_in[3] = 0; tick(4);
    check("R2 int after edge", int_out, 1);
    bus_rd(1'b0, d); check("R2 pending vector", d, 8'h08);

    // R5/R6/R7: acknowledge line 3 at spacing 4
    full_ack("IR3", 3);
    check("R7 int drops after take", int_out, 0);
    bus_rd(1'b0, d); check("R7 edge latch cleared", d, 8'h00);
    read_isr("R7 in-service line 3", 8'h08);

    // R4: lower line blocked, higher line nests
    irq_in[5] = 1; tick(4);
    check("R4 line 5 blocked by line 3", int_out, 0);
    irq_in[1] = 1; tick(4);
    check("R4 line 1 outranks line 3", int_out, 1);
    full_ack("IR1", 1);
    read_isr("R7 nested in-service", 8'h0A);

    // R9: end of interrupt
    bus_wr(1'b0, 8'h80);
    read_isr("R9 first eoi clears line 1", 8'h08);
    check("R9 line 5 still blocked", int_out, 0);
    bus_wr(1'b0, 8'h80);
    read_isr("R9 second eoi clears line 3", 8'h00);
    check("R9 line 5 released", int_out, 1);

    // R8: mask
    select(0); bus_wr(1'b1, 8'h20);
    check("R8 masked line silent", int_out, 0);
    bus_rd(1'b0, d); check("R8 masked line still pending", d, 8'h20);
    bus_wr(1'b1, 8'h00);
    check("R8 unmasked line raises", int_out, 1);

    // R6: spacing 8
    spc8 = 1; select(0);
    full_ack("IR5 spc8", 5);
    bus_wr(1'b0, 8'h80);
    irq_in[1] = 0; irq_in[5] = 0; tick(4);

    // R3: level mode on line 7
    select(1); bus_wr(1'b1, 8'h80);
    bus_rd(1'b1, d); check("R10 trig readback", d, 8'h80);
    irq_in[7] = 1; tick(4);
    check("R3 level high raises", int_out, 1);
    irq_in[7] = 0; tick(4);
    check("R3 level low clears", int_out, 0);
    irq_in[7] = 1; tick(4);
    full_ack("IR7 level", 7);
    check("R3 blocked while in service", int_out, 0);
    bus_wr(1'b0, 8'h80);
    check("R3 level re-raises after eoi", int_out, 1);
    irq_in[7] = 0; tick(4);
    check("R3 level dropped", int_out, 0);

    // R11: spurious acknowledge
    full_ack("R11 spurious", 7);
    read_isr("R11 in-service unchanged", 8'h00);
    check("R1 idle rdata at end", rdata, 0);

    tick(2);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule